// File: doc/BRIEF.md
# Quad-Channel DAC Serial Command Master

This block sends one 32-bit command word per request to a four-channel 12-bit digital-to-analog converter over a full-duplex serial link with chip select, serial clock, master-out and master-in lines. The user side presents a 4-bit command code, a 4-bit channel address and a 12-bit unsigned value, then pulses a start strobe. The block packs these fields into the command word, lowers chip select, and clocks the word out most significant bit first. It raises chip select once the last bit has been taken, and the converter begins its update on that rising edge.

The converter holds its input in a 32-bit shift register, so while a new word enters it returns the word it received in the previous transfer. The master captures this returned word on the same serial clock edges and reports it with a one-cycle done pulse. It also compares the returned word against the word it sent last time. The comparison is skipped on the first transfer after reset, because nothing has been sent yet. A runtime divider input sets the length of each serial clock half period in system clocks.

Top module: `dac_cmd_spi_master`

## Requirements
- R1: The transmitted word carries the command in bits 23..20, the channel address in bits 19..16 and the value in bits 15..4, with bits 31..24 and 3..0 sent as zero. The address passes through unchanged: 0 to 3 select one channel and 15 selects all channels.
- R2: The word is sent most significant bit first, with exactly 32 rising serial clock edges per transfer and one bit per edge.
- R3: The serial clock is low whenever chip select is high. Chip select falls before the first rising edge and rises only after the last falling edge.
- R4: The master-out line changes only while the serial clock is low, so it is stable across every rising edge.
- R5: Each serial clock half period lasts clk_div+1 system clocks, with clk_div latched at start. Chip select stays low for exactly 65*(clk_div+1) system clocks.
- R6: The master-in line is sampled on every rising serial clock edge, starting with the first rising edge after chip select falls. The 32 sampled bits, oldest bit in bit 31, appear on echo_word together with done.
- R7: echo_err, updated together with done, is 1 when echo_word differs from the word sent in the preceding transfer. It is 0 on the first transfer after reset.
- R8: A start strobe is ignored while busy is high. It neither alters the word in flight nor starts a second transfer.
- R9: done is a pulse one system clock long, raised in the clock after chip select returns high. busy is high from the clock after start is accepted until done.
- R10: After reset, chip select is high, serial clock, master-out, busy, done, echo_err and echo_word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| cmd | input | 4 | Command code |
| addr | input | 4 | Channel address |
| value | input | 12 | Unsigned conversion value |
| clk_div | input | DIV_W | Half period length minus one, in system clocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| echo_word | output | 32 | Word returned by the converter |
| echo_err | output | 1 | Returned word differs from the previously sent word |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_sck | output | 1 | Serial clock |
| dac_mosi | output | 1 | Serial data to the converter |
| dac_miso | input | 1 | Serial data from the converter |

## Verification
A wrong phase state or half-period counter shows up within one transfer in two ways: the number of rising edges differs from 32, or the measured chip-select low time departs from 65 half periods. A shifter fault corrupts the word that a bench-side converter model reconstructs at chip-select release. The same fault also corrupts the echo reported one transfer later. A fault in the stored previous word or the first-transfer flag appears at the next done as a wrong echo_err. Corrupting a single returned bit shows that the comparison reacts to a one-bit difference.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
   localparam int WORD_W   = 32;
   localparam int CMD_W    = 4;
   localparam int ADDR_W   = 4;
   localparam int DATA_W   = 12;
   localparam int CMD_LSB  = 20;
   localparam int ADDR_LSB = 16;
   localparam int DATA_LSB = 4;
   localparam int IDX_W    = $clog2(WORD_W);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_TRAIL,
      ST_POST
   } xfer_state_t;

   function automatic logic [WORD_W-1:0] pack_word(
      input logic [CMD_W-1:0]  c,
      input logic [ADDR_W-1:0] a,
      input logic [DATA_W-1:0] d
   );
      logic [WORD_W-1:0] w;
      w = '0;
      w[CMD_LSB  +: CMD_W]  = c;
      w[ADDR_LSB +: ADDR_W] = a;
      w[DATA_LSB +: DATA_W] = d;
      return w;
   endfunction
endpackage

// File: rtl/dac_half_timer.sv
module dac_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] reload_val,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == '0)
         cnt <= reload_val;
      else
         cnt <= cnt - 1'b1;
   end

   assign tick = run && (cnt == '0);
endmodule

// File: rtl/dac_word_shifter.sv
module dac_word_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              shift,
   input  logic              sample,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_word
);
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tx_q <= '0;
      else if (load)
         tx_q <= load_word;
      else if (shift)
         tx_q <= {tx_q[WORD_W-2:0], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rx_q <= '0;
      else if (sample)
         rx_q <= {rx_q[WORD_W-2:0], miso};
   end

   assign mosi    = tx_q[WORD_W-1];
   assign rx_word = rx_q;
endmodule

// File: rtl/dac_echo_check.sv
module dac_echo_check #(
   parameter int WORD_W   = 32,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [WORD_W-1:0] rx_word,
   input  logic [WORD_W-1:0] sent_word,
   output logic [WORD_W-1:0] echo_word,
   output logic              echo_err
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         echo_word <= '0;
      else if (fire)
         echo_word <= rx_word;
   end

   generate
      if (CHECK_EN) begin : g_check
         logic [WORD_W-1:0] prev_q;
         logic              have_prev;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q    <= '0;
               have_prev <= 1'b0;
               echo_err  <= 1'b0;
            end else if (fire) begin
               echo_err  <= have_prev && (rx_word != prev_q);
               prev_q    <= sent_word;
               have_prev <= 1'b1;
            end
         end
      end else begin : g_nocheck
         assign echo_err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dac_cmd_spi_master.sv
module dac_cmd_spi_master
   import dac_cmd_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter bit ECHO_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] value,
   input  logic [DIV_W-1:0]  clk_div,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] echo_word,
   output logic              echo_err,
   output logic              dac_cs_n,
   output logic              dac_sck,
   output logic              dac_mosi,
   input  logic              dac_miso
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 1..16");
      end
   endgenerate

   xfer_state_t       state;
   logic [IDX_W-1:0]  bit_idx;
   logic [DIV_W-1:0]  div_q;
   logic [WORD_W-1:0] word_q;
   logic              tick;
   logic              accept;
   logic              do_shift;
   logic              do_sample;
   logic [WORD_W-1:0] rx_word;
   logic [DIV_W-1:0]  reload_val;

   assign accept     = (state == ST_IDLE) && start;
   assign reload_val = (state == ST_IDLE) ? clk_div : div_q;
   assign do_sample  = tick && (state == ST_LEAD || state == ST_LOW);
   assign do_shift   = tick && (state == ST_HIGH) && (bit_idx != LAST_IDX);
   assign busy       = (state != ST_IDLE);

   dac_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy),
      .reload_val (reload_val),
      .tick       (tick)
   );

   dac_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_word (pack_word(cmd, addr, value)),
      .shift     (do_shift),
      .sample    (do_sample),
      .miso      (dac_miso),
      .mosi      (dac_mosi),
      .rx_word   (rx_word)
   );

   dac_echo_check #(.WORD_W(WORD_W), .CHECK_EN(ECHO_CHECK)) u_echo (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (state == ST_POST),
      .rx_word   (rx_word),
      .sent_word (word_q),
      .echo_word (echo_word),
      .echo_err  (echo_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         dac_cs_n <= 1'b1;
         dac_sck  <= 1'b0;
         bit_idx  <= '0;
         div_q    <= '0;
         word_q   <= '0;
         done     <= 1'b0;
      end else begin
         done <= (state == ST_POST);
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_LEAD;
                  dac_cs_n <= 1'b0;
                  div_q    <= clk_div;
                  word_q   <= pack_word(cmd, addr, value);
                  bit_idx  <= '0;
               end
            end
            ST_LEAD, ST_LOW: begin
               if (tick) begin
                  dac_sck <= 1'b1;
                  state   <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  dac_sck <= 1'b0;
                  if (bit_idx == LAST_IDX) begin
                     state <= ST_TRAIL;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     state   <= ST_LOW;
                  end
               end
            end
            ST_TRAIL: begin
               if (tick) begin
                  dac_cs_n <= 1'b1;
                  state    <= ST_POST;
               end
            end
            ST_POST: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dac_cmd_spi_master_chk.sv
module dac_cmd_spi_master_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic echo_err,
   input logic dac_cs_n,
   input logic dac_sck,
   input logic dac_mosi
);
   assert_cs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> dac_cs_n);

   assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dac_cs_n |-> !dac_sck);

   assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sck |-> $stable(dac_mosi));

   assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_cs_n) |-> ($past(start) && !$past(busy)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (dac_cs_n && !busy));

   assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(echo_err) |-> done);
endmodule

bind dac_cmd_spi_master dac_cmd_spi_master_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .echo_err (echo_err),
   .dac_cs_n (dac_cs_n),
   .dac_sck  (dac_sck),
   .dac_mosi (dac_mosi)
);

// File: tb/tb_dac_cmd_spi_master.sv
`timescale 1ns/1ps
module tb_dac_cmd_spi_master;
   localparam int DIV_W = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  cmd = '0;
   logic [3:0]  addr = '0;
   logic [11:0] value = '0;
   logic [DIV_W-1:0] clk_div = '0;
   logic        busy, done, echo_err;
   logic [31:0] echo_word;
   logic        dac_cs_n, dac_sck, dac_mosi;
   logic        dac_miso;

   int vectors = 0;
   int fails   = 0;

   always #10 clk = ~clk;

   dac_cmd_spi_master #(.DIV_W(DIV_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
      .value(value), .clk_div(clk_div), .busy(busy), .done(done),
      .echo_word(echo_word), .echo_err(echo_err), .dac_cs_n(dac_cs_n),
      .dac_sck(dac_sck), .dac_mosi(dac_mosi), .dac_miso(dac_miso)
   );

   // converter model
   logic [31:0] s_reg = 32'hA5C3_0F96;
   logic [31:0] s_got = '0;
   logic        s_miso = 1'b0;
   logic        corrupt = 1'b0;
   int          rises = 0;
   int          cs_falls = 0;
   assign dac_miso = s_miso;

   always @(negedge dac_cs_n) begin
      rises    = 0;
      cs_falls = cs_falls + 1;
      s_miso  <= s_reg[31] ^ (corrupt && rises == 5);
   end
   always @(posedge dac_sck) begin
      s_reg = {s_reg[30:0], dac_mosi};
      rises = rises + 1;
   end
   always @(negedge dac_sck) s_miso <= s_reg[31] ^ (corrupt && rises == 5);
   always @(posedge dac_cs_n) s_got = s_reg;

   // line monitors
   int   cs_len = 0;
   int   mosi_viol = 0;
   logic last_mosi = 1'b0;
   always @(negedge clk) begin
      if (!dac_cs_n) cs_len = cs_len + 1;
      if (dac_sck && dac_mosi != last_mosi) mosi_viol = mosi_viol + 1;
      last_mosi = dac_mosi;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors = vectors + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pack(input logic [3:0] c, input logic [3:0] a,
                                        input logic [11:0] d);
      return {8'h00, c, a, d, 4'h0};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1'b1; break; end
      end
   endtask

   task automatic do_xfer(input string tag, input logic [3:0] c, input logic [3:0] a,
                          input logic [11:0] d, input int div, input logic exp_err);
      logic [31:0] exp_echo;
      bit ok;
      exp_echo = s_reg ^ (corrupt ? 32'h0400_0000 : 32'h0);
      cs_len = 0;
      mosi_viol = 0;
      @(negedge clk);
      cmd = c; addr = a; value = d; clk_div = DIV_W'(div); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R9 busy after accept"}, 32'(busy), 32'd1);
      wait_done(ok);
      chk({tag, " R9 done seen"}, 32'(ok), 32'd1);
      chk({tag, " R1 R2 word at converter"}, s_got, pack(c, a, d));
      chk({tag, " R2 rising edges"}, 32'(rises), 32'd32);
      chk({tag, " R5 cs low clocks"}, 32'(cs_len), 32'(65 * (div + 1)));
      chk({tag, " R4 mosi moves while sck high"}, 32'(mosi_viol), 32'd0);
      chk({tag, " R6 echo word"}, echo_word, exp_echo);
      chk({tag, " R7 echo err"}, 32'(echo_err), 32'(exp_err));
      chk({tag, " R3 R9 cs high and idle at done"}, {30'd0, dac_cs_n, busy}, 32'd2);
      @(negedge clk);
      chk({tag, " R9 done width"}, 32'(done), 32'd0);
   endtask

   task automatic t_reset_state();
      chk("R10 reset outputs",
          {26'd0, dac_cs_n, dac_sck, dac_mosi, busy, done, echo_err}, 32'h20);
      chk("R10 reset echo_word", echo_word, 32'h0);
   endtask

   task automatic t_busy_ignore();
      int falls0;
      bit ok;
      falls0 = cs_falls;
      @(negedge clk);
      cmd = 4'h3; addr = 4'h2; value = 12'h5A5; clk_div = 8'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      cmd = 4'hC; addr = 4'h1; value = 12'h0F0; clk_div = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      repeat (6) @(negedge clk);
      chk("R8 word unchanged by busy start", s_got, pack(4'h3, 4'h2, 12'h5A5));
      chk("R8 single transfer", 32'(cs_falls - falls0), 32'd1);
      chk("R8 idle afterwards", {30'd0, busy, dac_cs_n}, 32'd1);
   endtask

   initial begin
      #(200000 * 20);
      fails = fails + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      do_reset();
      t_reset_state();
      // first transfer: echo differs from anything sent, flag suppressed (R7)
      do_xfer("x1", 4'h3, 4'h0, 12'h123, 0, 1'b0);
      do_xfer("x2", 4'h3, 4'h2, 12'hABC, 3, 1'b0);
      do_xfer("x3 all channels", 4'hF, 4'hF, 12'hFFF, 1, 1'b0);
      corrupt = 1'b1;
      do_xfer("x4 corrupted echo", 4'h0, 4'h1, 12'h800, 2, 1'b1);
      corrupt = 1'b0;
      do_xfer("x5 clean after corruption", 4'h2, 4'h3, 12'h001, 0, 1'b0);
      t_busy_ignore();
      // after reset the first compare is suppressed again
      do_reset();
      t_reset_state();
      s_reg = 32'h1357_9BDF;
      do_xfer("x6 first after reset", 4'h1, 4'h0, 12'h7E1, 1, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule